// File: doc/BRIEF.md
# Pipelined YCbCr to RGB666 Colour Converter

This block turns one studio-range colour sample per pixel clock, given as separate 8-bit luma (Y) and blue/red chroma (Cb, Cr) buses, into an 18-bit RGB666 word. The conversion uses fixed-point constant multiplies scaled by 256, adds rounding, and saturates each channel to 0..255. The upper six bits of each saturated channel are then packed into the output word. Chroma must already be present on every pixel. Any upsampling of subsampled chroma is done upstream.

The datapath is a fixed four-register pipeline: scale, sum, clamp, and output register. The horizontal sync, vertical sync, field flag and data-enable inputs go through a delay line of the same depth, so each control value leaves the block on the same clock as the pixel it came with. Conversion does not depend on data-enable. Reset is synchronous and active high.

Top module: `ycc2rgb666`

## Requirements
- R1: The red field o_rgb[17:12] equals bits 7:2 of clamp(floor((298·(Y−16) + 409·(Cr−128) + 128) / 256)), where clamp limits to 0..255.
- R2: The green field o_rgb[11:6] equals bits 7:2 of clamp(floor((298·(Y−16) − 208·(Cr−128) − 100·(Cb−128) + 128) / 256)).
- R3: The blue field o_rgb[5:0] equals bits 7:2 of clamp(floor((298·(Y−16) + 516·(Cb−128) + 128) / 256)).
- R4: A channel whose scaled result exceeds 255 saturates to all ones (6'h3F). It does not wrap.
- R5: A channel whose scaled result is negative saturates to zero. In particular, Y below 16 with Cb = Cr = 128 gives o_rgb = 0.
- R6: A pixel presented before clock edge n appears on o_rgb right after edge n+3, which is four registering edges. Before that edge, o_rgb still shows the earlier pixel.
- R7: o_hsync, o_vsync, o_field and o_den equal i_hsync, i_vsync, i_field and i_den as sampled four edges earlier.
- R8: An edge with rst high clears o_rgb and all four control outputs to zero. After rst falls, the outputs stay zero until the first pixel sampled after reset reaches the output four edges later.
- R9: i_den has no effect on the colour result. A pixel presented with i_den low is converted the same way as one presented with i_den high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| i_hsync | input | 1 | Horizontal sync in |
| i_vsync | input | 1 | Vertical sync in |
| i_field | input | 1 | Odd/even field flag in |
| i_den | input | 1 | Data enable in |
| i_y | input | 8 | Luma sample |
| i_cb | input | 8 | Blue-difference chroma sample |
| i_cr | input | 8 | Red-difference chroma sample |
| o_hsync | output | 1 | Horizontal sync, delayed four cycles |
| o_vsync | output | 1 | Vertical sync, delayed four cycles |
| o_field | output | 1 | Field flag, delayed four cycles |
| o_den | output | 1 | Data enable, delayed four cycles |
| o_rgb | output | 18 | Packed RGB666 pixel, red in the top field |

## Verification
The black, white and pure red, green and blue points each load a different coefficient path. A swapped or mis-signed coefficient therefore moves only some of the three fields. Extreme inputs, such as full-scale luma with full-scale chroma and luma below the black level, separate saturation from wrap-around at both ends. A stream of changing pixels with random control bits, sampled each cycle, separates the correct four-edge latency from a pipeline that is one stage short or one stage long. It also shows whether the control bits stay aligned with their pixels. Checks around reset release and a pixel presented with data-enable low cover the clearing and the independence of the colour path from data-enable.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int IN_W      = 8;
    localparam int DIFF_W    = IN_W + 2;
    localparam int PROD_W    = 20;
    localparam int SUM_W     = 21;
    localparam int CH_W      = 8;
    localparam int OUT_CH_W  = 6;
    localparam int N_CH      = 3;
    localparam int PIPE_LAT  = 4;
    localparam int CTL_LAT   = PIPE_LAT;
    localparam int RGB_W     = N_CH * OUT_CH_W;
    localparam int FRAC      = 8;
    localparam int ROUND_ADD = 1 << (FRAC - 1);
    localparam int CH_MAX    = (1 << CH_W) - 1;

    localparam int LUMA_OFF   = 16;
    localparam int CHROMA_OFF = 128;

    localparam int K_LUMA = 298;
    localparam int K_CR_R = 409;
    localparam int K_CR_G = 208;
    localparam int K_CB_G = 100;
    localparam int K_CB_B = 516;

    localparam int IDX_R = 2;
    localparam int IDX_G = 1;
    localparam int IDX_B = 0;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic field;
        logic den;
    } vid_ctl_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] luma;
        logic signed [PROD_W-1:0] cr_r;
        logic signed [PROD_W-1:0] cr_g;
        logic signed [PROD_W-1:0] cb_g;
        logic signed [PROD_W-1:0] cb_b;
    } prod_t;

    typedef logic [N_CH-1:0][SUM_W-1:0] sum_vec_t;
    typedef logic [N_CH-1:0][CH_W-1:0]  chan_vec_t;

    function automatic logic signed [DIFF_W-1:0] offset_diff(
        input logic [IN_W-1:0] s,
        input int              off
    );
        logic signed [DIFF_W-1:0] a;
        logic signed [DIFF_W-1:0] b;
        a = $signed({2'b00, s});
        b = DIFF_W'(off);
        return a - b;
    endfunction

    function automatic logic signed [PROD_W-1:0] scale_const(
        input logic signed [DIFF_W-1:0] d,
        input int                       k
    );
        logic signed [PROD_W-1:0] de;
        logic signed [PROD_W-1:0] ke;
        de = PROD_W'(d);
        ke = PROD_W'(k);
        return de * ke;
    endfunction

    function automatic logic signed [SUM_W-1:0] widen(
        input logic signed [PROD_W-1:0] p
    );
        return SUM_W'(p);
    endfunction

    function automatic logic [CH_W-1:0] clamp_chan(
        input logic signed [SUM_W-1:0] s
    );
        logic signed [SUM_W-1:0] t;
        t = s >>> FRAC;
        if (t < 0) begin
            return '0;
        end else if (t > SUM_W'(CH_MAX)) begin
            return CH_W'(CH_MAX);
        end else begin
            return t[CH_W-1:0];
        end
    endfunction

endpackage

// File: rtl/ycc_scale_stage.sv
module ycc_scale_stage
    import ycc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] y,
    input  logic [IN_W-1:0] cb,
    input  logic [IN_W-1:0] cr,
    output prod_t           prod
);

    logic signed [DIFF_W-1:0] dy;
    logic signed [DIFF_W-1:0] dcb;
    logic signed [DIFF_W-1:0] dcr;
    prod_t                    prod_d;

    always_comb begin
        dy          = offset_diff(y, LUMA_OFF);
        dcb         = offset_diff(cb, CHROMA_OFF);
        dcr         = offset_diff(cr, CHROMA_OFF);
        prod_d.luma = scale_const(dy, K_LUMA);
        prod_d.cr_r = scale_const(dcr, K_CR_R);
        prod_d.cr_g = scale_const(dcr, K_CR_G);
        prod_d.cb_g = scale_const(dcb, K_CB_G);
        prod_d.cb_b = scale_const(dcb, K_CB_B);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else begin
            prod <= prod_d;
        end
    end

endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
    import ycc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  prod_t    prod,
    output sum_vec_t sums
);

    logic signed [SUM_W-1:0] luma_w;
    logic signed [SUM_W-1:0] rnd;
    sum_vec_t                sums_d;

    always_comb begin
        luma_w        = widen(prod.luma);
        rnd           = SUM_W'(ROUND_ADD);
        sums_d[IDX_R] = luma_w + widen(prod.cr_r) + rnd;
        sums_d[IDX_G] = luma_w - widen(prod.cr_g) - widen(prod.cb_g) + rnd;
        sums_d[IDX_B] = luma_w + widen(prod.cb_b) + rnd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sums <= '0;
        end else begin
            sums <= sums_d;
        end
    end

endmodule

// File: rtl/ycc_clamp_stage.sv
module ycc_clamp_stage
    import ycc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sum_vec_t  sums,
    output chan_vec_t chans
);

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                chans[c] <= '0;
            end else begin
                chans[c] <= clamp_chan($signed(sums[c]));
            end
        end
    end

endmodule

// File: rtl/ycc_ctl_delay.sv
module ycc_ctl_delay
    import ycc_pkg::*;
#(
    parameter int DEPTH = CTL_LAT
) (
    input  logic     clk,
    input  logic     rst,
    input  vid_ctl_t ctl_in,
    output vid_ctl_t ctl_out
);

    vid_ctl_t tap [DEPTH+1];

    assign tap[0] = ctl_in;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                tap[s+1] <= '0;
            end else begin
                tap[s+1] <= tap[s];
            end
        end
    end

    assign ctl_out = tap[DEPTH];

endmodule

// File: rtl/ycc2rgb666.sv
module ycc2rgb666
    import ycc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             i_hsync,
    input  logic             i_vsync,
    input  logic             i_field,
    input  logic             i_den,
    input  logic [IN_W-1:0]  i_y,
    input  logic [IN_W-1:0]  i_cb,
    input  logic [IN_W-1:0]  i_cr,
    output logic             o_hsync,
    output logic             o_vsync,
    output logic             o_field,
    output logic             o_den,
    output logic [RGB_W-1:0] o_rgb
);

    prod_t     prod_q;
    sum_vec_t  sums_q;
    chan_vec_t chans_q;
    vid_ctl_t  ctl_in;
    vid_ctl_t  ctl_out;
    logic [RGB_W-1:0] rgb_d;

    ycc_scale_stage u_scale (
        .clk  (clk),
        .rst  (rst),
        .y    (i_y),
        .cb   (i_cb),
        .cr   (i_cr),
        .prod (prod_q)
    );

    ycc_sum_stage u_sum (
        .clk  (clk),
        .rst  (rst),
        .prod (prod_q),
        .sums (sums_q)
    );

    ycc_clamp_stage u_clamp (
        .clk   (clk),
        .rst   (rst),
        .sums  (sums_q),
        .chans (chans_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_pack
        assign rgb_d[c*OUT_CH_W +: OUT_CH_W] = chans_q[c][CH_W-1 -: OUT_CH_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_rgb <= '0;
        end else begin
            o_rgb <= rgb_d;
        end
    end

    assign ctl_in = '{hsync: i_hsync, vsync: i_vsync, field: i_field, den: i_den};

    ycc_ctl_delay #(.DEPTH(CTL_LAT)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_in),
        .ctl_out (ctl_out)
    );

    assign o_hsync = ctl_out.hsync;
    assign o_vsync = ctl_out.vsync;
    assign o_field = ctl_out.field;
    assign o_den   = ctl_out.den;

endmodule

// File: rtl/ycc2rgb666_chk.sv
module ycc2rgb666_chk
    import ycc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             i_hsync,
    input logic             i_vsync,
    input logic             i_field,
    input logic             i_den,
    input logic [IN_W-1:0]  i_y,
    input logic [IN_W-1:0]  i_cb,
    input logic [IN_W-1:0]  i_cr,
    input logic             o_hsync,
    input logic             o_vsync,
    input logic             o_field,
    input logic             o_den,
    input logic [RGB_W-1:0] o_rgb
);

    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < 3'(PIPE_LAT)) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assign warm = (since_rst == 3'(PIPE_LAT));

    // R8: reset clears everything on the next edge
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (o_rgb == '0 && !o_hsync && !o_vsync && !o_field && !o_den));

    // R7: control bits follow their inputs four edges later
    assert_ctl_delay_R7: assert property (@(posedge clk) disable iff (rst)
        warm |-> (o_hsync == $past(i_hsync, 4) && o_vsync == $past(i_vsync, 4) &&
                  o_field == $past(i_field, 4) && o_den == $past(i_den, 4)));

    // R5: luma below black with neutral chroma floors every channel
    assert_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(i_y, 4) < 8'd16 && $past(i_cb, 4) == 8'd128 &&
         $past(i_cr, 4) == 8'd128) |-> (o_rgb == '0));

    // R4: full luma plus full red chroma pins red at the top
    assert_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(i_y, 4) == 8'hFF && $past(i_cr, 4) == 8'hFF)
        |-> (o_rgb[17:12] == 6'h3F));

endmodule

bind ycc2rgb666 ycc2rgb666_chk u_chk (.*);

// File: tb/ycc2rgb666_tb.sv
`timescale 1ns/1ps
module ycc2rgb666_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        i_hsync, i_vsync, i_field, i_den;
    logic [7:0]  i_y, i_cb, i_cr;
    logic        o_hsync, o_vsync, o_field, o_den;
    logic [17:0] o_rgb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ycc2rgb666 u_dut (
        .clk(clk), .rst(rst),
        .i_hsync(i_hsync), .i_vsync(i_vsync), .i_field(i_field), .i_den(i_den),
        .i_y(i_y), .i_cb(i_cb), .i_cr(i_cr),
        .o_hsync(o_hsync), .o_vsync(o_vsync), .o_field(o_field), .o_den(o_den),
        .o_rgb(o_rgb)
    );

    function automatic logic [5:0] chan6(int acc);
        int s;
        s = (acc + 128) >>> 8;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return 6'(s >> 2);
    endfunction

    function automatic logic [17:0] model(logic [7:0] y, logic [7:0] cb, logic [7:0] cr);
        int dy, db, dr;
        dy = int'(y) - 16;
        db = int'(cb) - 128;
        dr = int'(cr) - 128;
        return {chan6(298*dy + 409*dr),
                chan6(298*dy - 208*dr - 100*db),
                chan6(298*dy + 516*db)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] y, logic [7:0] cb, logic [7:0] cr, logic [3:0] c);
        i_y = y; i_cb = cb; i_cr = cr;
        {i_hsync, i_vsync, i_field, i_den} = c;
    endtask

    task automatic apply_and_check(string req, string what,
                                   logic [7:0] y, logic [7:0] cb, logic [7:0] cr, logic den);
        @(negedge clk);
        drive(y, cb, cr, {3'b000, den});
        repeat (4) @(negedge clk);
        check(req, what, 32'(o_rgb), 32'(model(y, cb, cr)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        drive(8'd200, 8'd30, 8'd220, 4'hF);
        rst = 1'b1;
        @(negedge clk);
        check("R8", "rgb during reset", 32'(o_rgb), 32'd0);
        check("R8", "ctl during reset", 32'({o_hsync, o_vsync, o_field, o_den}), 32'd0);
        rst = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R8", "rgb held low after release", 32'(o_rgb), 32'd0);
        end
        @(negedge clk);
        check("R8", "first pixel after release", 32'(o_rgb), 32'(model(8'd200, 8'd30, 8'd220)));
        check("R7", "ctl after release", 32'({o_hsync, o_vsync, o_field, o_den}), 32'hF);
    endtask

    task automatic t_colours();
        apply_and_check("R1", "black", 8'd16, 8'd128, 8'd128, 1'b1);
        check("R5", "black is zero", 32'(o_rgb), 32'd0);
        apply_and_check("R1", "white", 8'd235, 8'd128, 8'd128, 1'b1);
        check("R4", "white is all ones", 32'(o_rgb), 32'h3FFFF);
        apply_and_check("R1", "red", 8'd81, 8'd90, 8'd240, 1'b1);
        apply_and_check("R2", "green", 8'd145, 8'd54, 8'd34, 1'b1);
        apply_and_check("R3", "blue", 8'd41, 8'd240, 8'd110, 1'b1);
        apply_and_check("R2", "mid grey tint", 8'd120, 8'd100, 8'd160, 1'b1);
    endtask

    task automatic t_saturate();
        apply_and_check("R4", "red overflow", 8'd255, 8'd128, 8'd255, 1'b1);
        check("R4", "red field top", 32'(o_rgb[17:12]), 32'h3F);
        apply_and_check("R4", "blue overflow", 8'd255, 8'd255, 8'd128, 1'b1);
        check("R4", "blue field top", 32'(o_rgb[5:0]), 32'h3F);
        apply_and_check("R5", "below black", 8'd0, 8'd128, 8'd128, 1'b1);
        check("R5", "below black zero", 32'(o_rgb), 32'd0);
        apply_and_check("R5", "green underflow", 8'd16, 8'd255, 8'd255, 1'b1);
        check("R5", "green field zero", 32'(o_rgb[11:6]), 32'd0);
    endtask

    task automatic t_den_ignored();
        apply_and_check("R9", "den low converts", 8'd81, 8'd90, 8'd240, 1'b0);
        check("R9", "den low ctl out", 32'(o_den), 32'd0);
    endtask

    task automatic t_stream();
        logic [7:0] hy [64];
        logic [7:0] hb [64];
        logic [7:0] hr [64];
        logic [3:0] hc [64];
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (k >= 4) begin
                check("R6", "stream pixel", 32'(o_rgb), 32'(model(hy[k-4], hb[k-4], hr[k-4])));
                check("R7", "stream ctl", 32'({o_hsync, o_vsync, o_field, o_den}), 32'(hc[k-4]));
            end
            hy[k] = 8'($urandom);
            hb[k] = 8'($urandom);
            hr[k] = 8'($urandom);
            hc[k] = 4'($urandom);
            drive(hy[k], hb[k], hr[k], hc[k]);
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(8'd0, 8'd0, 8'd0, 4'h0);
        repeat (3) @(negedge clk);
        check("R8", "initial rgb zero", 32'(o_rgb), 32'd0);
        rst = 1'b0;
        t_colours();
        t_saturate();
        t_den_ignored();
        t_stream();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule